// File: doc/BRIEF.md
# Frame Buffer Run Fill and Copy Engine

This engine paints or moves short horizontal runs of byte pixels in an 8-bit frame buffer. A processor drives it through a command stream. Each command is one 32-bit bus access, and a full operation takes two of them.

- A word written at an address with bit 2 clear stores a pending fill colour.
- A word written at an address with bit 2 set launches a run. The destination pixel comes from the bus address. The data word holds a source pixel address and a length.

When the source field is all ones the run is a fill: every destination pixel receives the low byte of the stored colour. Any other source value makes the run a copy. The copy reads and writes pixels in ascending order, one read and one write per pixel.

The engine drives a single-port synchronous byte RAM. The RAM returns read data one cycle after the request. The command port is valid/ready. A command transfers in a cycle where both `cmd_valid` and `cmd_ready` are high. While a run is in progress `cmd_ready` stays low, so every command waits, not only a new launch. The requester must hold the command and its fields steady until the transfer. A read transfer is answered one cycle later on `rsp_valid`. That response has no back-pressure and its data is always zero. `busy` and `done` are plain status pins.

Top module: `fb_runblit_top`

## Requirements
- R1: An accepted 32-bit write with `cmd_addr[2]`=0 stores `cmd_wdata[7:0]` as the pending colour. It starts no run: `busy` stays low and no RAM access is made.
- R2: An accepted 32-bit write with `cmd_addr[2]`=1 starts a run. Its destination pixel address is `cmd_addr[22:3]`, which is the bus address shifted right by 3 and kept to 20 bits. Higher address bits have no effect.
- R3: The run length is `cmd_wdata[28:24]` + 1, so one to 32 pixels are touched. Pixels outside the run keep their contents.
- R4: When `cmd_wdata[23:0]` is 0xFFFFFF the run is a fill. Each destination pixel gets the pending colour's low byte. A fill takes one cycle per pixel.
- R5: With any other source value the run is a copy. For each i from 0 to length-1, pixel source+i is written to destination+i. A copy takes two cycles per pixel, a read followed by a write.
- R6: A copy runs in ascending address order. A copy whose destination overlaps the source ahead of it gives the result of a byte-by-byte forward copy.
- R7: Every accepted read is answered one cycle later with `rsp_valid`=1 and `rsp_data`=0.
- R8: Writes whose `cmd_size` is not 2 (32-bit) are ignored. They change neither the pending colour nor the RAM.
- R9: `busy` rises in the cycle after a launch is accepted and stays high until the cycle of the last pixel write. While `busy` is high, `cmd_ready` is low and commands are held off.
- R10: `done` is high for exactly one cycle. That cycle is the one after the final pixel write, and `busy` is low in it.
- R11: After reset, `busy`, `done`, `rsp_valid` and `mem_req` are 0, `cmd_ready` is 1, and the pending colour is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine accepts a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 24 | Byte address within the command window |
| cmd_wdata | input | 32 | Write data |
| cmd_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 double |
| rsp_valid | output | 1 | Read response present |
| rsp_data | output | 32 | Read response data (always zero) |
| mem_req | output | 1 | RAM access this cycle |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 20 | RAM pixel address |
| mem_wdata | output | 8 | RAM write byte |
| mem_rdata | input | 8 | RAM read byte, one cycle after request |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle run completion pulse |

## Verification
The bench checks the length edges of a single pixel and 32 pixels. It also compares the whole RAM image after each run. A length off by one would touch one pixel too many or too few, and a wrong cycle count would move the `done` pulse. A copy whose destination sits one byte above its source must smear the first byte across the run; an engine that buffered reads ahead would instead copy the original bytes. Further tests cover a launch with a high address bit set, a half-word write, and a command offered while busy. Against these, a design that decoded the destination with the wrong shift, accepted a non-word store, or let a command through mid-run would write to the wrong place or at the wrong time.

// File: rtl/fbb_pkg.sv
package fbb_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_FILL  = 2'd1,
    SEQ_READ  = 2'd2,
    SEQ_WRITE = 2'd3
  } seq_state_e;

  localparam logic [1:0] ACC_WORD = 2'd2;
endpackage

// File: rtl/fbb_cmd_decode.sv
module fbb_cmd_decode
  import fbb_pkg::*;
#(
  parameter int BUS_AW = 24,
  parameter int PIX_AW = 20,
  parameter int SRC_W  = 24,
  parameter int LEN_W  = 5,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [BUS_AW-1:0] cmd_addr,
  input  logic [DW-1:0]     cmd_wdata,
  input  logic [1:0]        cmd_size,
  input  logic              busy,
  output logic              start,
  output logic [PIX_AW-1:0] start_dst,
  output logic [SRC_W-1:0]  start_src,
  output logic [LEN_W-1:0]  start_len_m1,
  output logic [7:0]        colour,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_data
);
  localparam int LEN_LSB = SRC_W;

  logic accept;
  logic word_wr;
  logic [7:0] colour_q;
  logic rsp_q;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign word_wr   = accept && cmd_write && (cmd_size == ACC_WORD);
  assign start     = word_wr && cmd_addr[2];

  assign start_dst    = cmd_addr[PIX_AW+2:3];
  assign start_src    = cmd_wdata[SRC_W-1:0];
  assign start_len_m1 = cmd_wdata[LEN_LSB+LEN_W-1:LEN_LSB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      colour_q <= 8'h00;
      rsp_q    <= 1'b0;
    end else begin
      if (word_wr && !cmd_addr[2]) colour_q <= cmd_wdata[7:0];
      rsp_q <= accept && !cmd_write;
    end
  end

  assign colour    = colour_q;
  assign rsp_valid = rsp_q;
  assign rsp_data  = '0;

  logic unused_bits;
  assign unused_bits = ^{cmd_wdata[DW-1:LEN_LSB+LEN_W], cmd_addr[1:0],
                         cmd_addr[BUS_AW-1:PIX_AW+3]};
endmodule

// File: rtl/fbb_run_seq.sv
module fbb_run_seq
  import fbb_pkg::*;
#(
  parameter int PIX_AW = 20,
  parameter int SRC_W  = 24,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PIX_AW-1:0] start_dst,
  input  logic [SRC_W-1:0]  start_src,
  input  logic [LEN_W-1:0]  start_len_m1,
  input  logic [7:0]        colour,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PIX_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              done
);
  localparam logic [SRC_W-1:0] FILL_CODE = {SRC_W{1'b1}};

  seq_state_e state_q;
  logic [PIX_AW-1:0] dst_q, src_q;
  logic [LEN_W-1:0]  len_q, idx_q;
  logic [7:0]        col_q;
  logic              done_q;
  logic [PIX_AW-1:0] idx_ext;
  logic              last_px;
  logic              wr_fire;

  assign idx_ext = {{(PIX_AW-LEN_W){1'b0}}, idx_q};
  assign last_px = (idx_q == len_q);
  assign wr_fire = (state_q == SEQ_FILL) || (state_q == SEQ_WRITE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      dst_q   <= '0;
      src_q   <= '0;
      len_q   <= '0;
      idx_q   <= '0;
      col_q   <= 8'h00;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            dst_q   <= start_dst;
            src_q   <= start_src[PIX_AW-1:0];
            len_q   <= start_len_m1;
            col_q   <= colour;
            idx_q   <= '0;
            state_q <= (start_src == FILL_CODE) ? SEQ_FILL : SEQ_READ;
          end
        end
        SEQ_FILL: begin
          if (last_px) begin
            state_q <= SEQ_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        SEQ_READ: state_q <= SEQ_WRITE;
        SEQ_WRITE: begin
          if (last_px) begin
            state_q <= SEQ_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= SEQ_READ;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = (state_q != SEQ_IDLE);
    mem_we    = wr_fire;
    mem_addr  = (state_q == SEQ_READ) ? (src_q + idx_ext) : (dst_q + idx_ext);
    mem_wdata = (state_q == SEQ_FILL) ? col_q : mem_rdata;
  end

  assign busy = (state_q != SEQ_IDLE);
  assign done = done_q;

  logic unused_src;
  assign unused_src = ^start_src;
endmodule

// File: rtl/fb_runblit_top.sv
module fb_runblit_top
  import fbb_pkg::*;
#(
  parameter int BUS_AW = 24,
  parameter int PIX_AW = 20,
  parameter int SRC_W  = 24,
  parameter int LEN_W  = 5,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [BUS_AW-1:0] cmd_addr,
  input  logic [DW-1:0]     cmd_wdata,
  input  logic [1:0]        cmd_size,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PIX_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              done
);
  logic              start;
  logic [PIX_AW-1:0] start_dst;
  logic [SRC_W-1:0]  start_src;
  logic [LEN_W-1:0]  start_len_m1;
  logic [7:0]        colour;

  fbb_cmd_decode #(
    .BUS_AW(BUS_AW), .PIX_AW(PIX_AW), .SRC_W(SRC_W), .LEN_W(LEN_W), .DW(DW)
  ) dec_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_size(cmd_size), .busy(busy), .start(start), .start_dst(start_dst),
    .start_src(start_src), .start_len_m1(start_len_m1), .colour(colour),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  fbb_run_seq #(
    .PIX_AW(PIX_AW), .SRC_W(SRC_W), .LEN_W(LEN_W)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_dst(start_dst),
    .start_src(start_src), .start_len_m1(start_len_m1), .colour(colour),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done)
  );
endmodule

// File: rtl/fbb_checker.sv
module fbb_checker #(
  parameter int BUS_AW = 24,
  parameter int PIX_AW = 20,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_write,
  input logic [BUS_AW-1:0] cmd_addr,
  input logic [1:0]        cmd_size,
  input logic              rsp_valid,
  input logic [DW-1:0]     rsp_data,
  input logic              mem_req,
  input logic              mem_we,
  input logic              busy,
  input logic              done
);
  logic launch_acc, colour_acc;
  assign launch_acc = cmd_valid && cmd_ready && cmd_write && (cmd_size == 2'd2) && cmd_addr[2];
  assign colour_acc = cmd_valid && cmd_ready && cmd_write && (cmd_size == 2'd2) && !cmd_addr[2];

  // R1: a colour store leaves the engine idle
  assert_colour_noop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    colour_acc |=> !busy);
  // R1: no RAM traffic while idle
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  // R7: read responses carry zero
  assert_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_data == '0));
  // R9: launch makes the engine busy next cycle
  assert_launch_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    launch_acc |=> busy);
  // R9: busy only rises after an accepted launch
  assert_busy_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(launch_acc));
  // R10: done is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: done follows a pixel write and finds the engine idle
  assert_done_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(mem_req && mem_we) && !busy));
endmodule

bind fb_runblit_top fbb_checker #(.BUS_AW(BUS_AW), .PIX_AW(PIX_AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_size(cmd_size),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_req(mem_req),
  .mem_we(mem_we), .busy(busy), .done(done)
);

// File: tb/fb_runblit_tb_top.sv
`timescale 1ns/1ps
module fb_runblit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_write = 1'b0;
  logic [23:0] cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic [1:0]  cmd_size = 2'd2;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        mem_req, mem_we;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic        busy, done;

  always #2.5 clk = ~clk;

  fb_runblit_top dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_size(cmd_size), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done)
  );

  logic [7:0] ram [0:4095];
  logic [7:0] expm [0:4095];
  int wr_count = 0;
  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      ram[mem_addr[11:0]] <= mem_wdata;
      wr_count <= wr_count + 1;
    end
    if (mem_req && !mem_we) mem_rdata <= ram[mem_addr[11:0]];
  end

  // {dst[11:0], src[23:0], len_m1[4:0], colour[7:0]}
  localparam logic [48:0] VEC [0:6] = '{
    {12'h100, 24'hFFFFFF, 5'd3,  8'hA5},
    {12'h200, 24'h000040, 5'd7,  8'h11},
    {12'h300, 24'hFFFFFF, 5'd31, 8'h3C},
    {12'h400, 24'hFFFFFF, 5'd0,  8'h77},
    {12'h501, 24'h000500, 5'd15, 8'h22},
    {12'h600, 24'h000080, 5'd31, 8'h33},
    {12'h700, 24'h000704, 5'd9,  8'h44}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        finish_run();
      end
    end
  end

  task automatic bus_op(input bit wr, input logic [23:0] a, input logic [31:0] d,
                        input logic [1:0] sz);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d; cmd_size = sz;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_write = 1'b0; cmd_size = 2'd2;
  endtask

  task automatic model(input int dst, input int src, input int lm1, input logic [7:0] col);
    for (int i = 0; i <= lm1; i++) begin
      if (src == 24'hFFFFFF) expm[(dst + i) & 12'hFFF] = col;
      else expm[(dst + i) & 12'hFFF] = expm[(src + i) & 12'hFFF];
    end
  endtask

  task automatic compare_ram(input string tag);
    int bad = 0;
    int first_a = 0;
    for (int i = 0; i < 4096; i++)
      if (ram[i] !== expm[i]) begin
        if (bad == 0) first_a = i;
        bad++;
      end
    check(bad == 0, tag, ram[first_a], expm[first_a]);
  endtask

  task automatic settle();
    int g = 0;
    while ((busy || done) && g < 200) begin @(negedge clk); g++; end
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin
      ram[i] = 8'(i ^ (i >> 4) ^ 8'h5A);
      expm[i] = ram[i];
    end
    repeat (3) @(negedge clk);
    // R11: reset state
    check(busy == 0 && done == 0 && rsp_valid == 0 && mem_req == 0, "R11 idle outputs", {busy, done, mem_req}, 0);
    check(cmd_ready == 1, "R11 ready", cmd_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: pending colour resets to zero: fill without any colour store
    bus_op(1, {9'd0, 12'h0F0, 3'b100}, {3'd0, 5'd1, 24'hFFFFFF}, 2'd2);
    model(12'h0F0, 24'hFFFFFF, 1, 8'h00);
    settle();
    compare_ram("R11 reset colour");

    // vector table
    for (int v = 0; v < 7; v++) begin
      int dst, src, lm1, cnt, g;
      logic [7:0] col;
      string tg;
      dst = VEC[v][48:37]; src = VEC[v][36:13]; lm1 = VEC[v][12:8]; col = VEC[v][7:0];
      tg = (src == 24'hFFFFFF) ? "R4" : ((v == 4) ? "R6" : "R5");
      bus_op(1, 24'h000000, {24'hABCDEF, col}, 2'd2);
      bus_op(1, {9'd0, dst[11:0], 3'b100}, {3'd0, lm1[4:0], src[23:0]}, 2'd2);
      model(dst, src, lm1, col);
      cnt = 0; g = 0;
      while (!done && g < 200) begin
        if (busy) cnt++;
        @(negedge clk);
        g++;
      end
      check(cnt == ((src == 24'hFFFFFF) ? (lm1 + 1) : 2 * (lm1 + 1)), "R3 busy cycles", cnt,
            (src == 24'hFFFFFF) ? (lm1 + 1) : 2 * (lm1 + 1));
      check(done && !busy, "R10 done with busy low", {done, busy}, 2'b10);
      @(negedge clk);
      check(!done, "R10 done single cycle", done, 0);
      compare_ram({tg, " run image"});
    end

    // R1: colour store starts nothing
    begin
      int w0;
      w0 = wr_count;
      bus_op(1, 24'h000010, 32'h000000C3, 2'd2);
      check(!busy, "R1 no busy", busy, 0);
      repeat (4) @(negedge clk);
      check(wr_count == w0, "R1 no ram writes", wr_count, w0);
    end

    // R8: half-word launch ignored
    begin
      int w0;
      w0 = wr_count;
      bus_op(1, {9'd0, 12'h900, 3'b100}, {3'd0, 5'd3, 24'hFFFFFF}, 2'd1);
      repeat (4) @(negedge clk);
      check(wr_count == w0 && !busy, "R8 sub-word launch ignored", wr_count, w0);
    end
    // R8: byte colour store ignored, fill keeps C3
    bus_op(1, 24'h000000, 32'h0000005E, 2'd0);
    bus_op(1, {9'd0, 12'h910, 3'b100}, {3'd0, 5'd2, 24'hFFFFFF}, 2'd2);
    model(12'h910, 24'hFFFFFF, 2, 8'hC3);
    settle();
    compare_ram("R8 colour unchanged");

    // R2: high address bit above destination field is dropped
    bus_op(1, {1'b1, 8'd0, 12'hA20, 3'b100}, {3'd0, 5'd1, 24'hFFFFFF}, 2'd2);
    model(12'hA20, 24'hFFFFFF, 1, 8'hC3);
    settle();
    compare_ram("R2 destination decode");

    // R7: reads return zero
    bus_op(0, 24'h000004, 32'h0, 2'd2);
    check(rsp_valid == 1 && rsp_data == 0, "R7 read zero", rsp_data, 0);
    @(negedge clk);
    check(rsp_valid == 0, "R7 single response", rsp_valid, 0);

    // R9: hold-off while busy
    bus_op(1, {9'd0, 12'hB00, 3'b100}, {3'd0, 5'd31, 24'hFFFFFF}, 2'd2);
    check(busy && !cmd_ready, "R9 ready low while busy", cmd_ready, 0);
    bus_op(1, {9'd0, 12'hB10, 3'b100}, {3'd0, 5'd1, 24'h000300}, 2'd2);
    model(12'hB00, 24'hFFFFFF, 31, 8'hC3);
    model(12'hB10, 24'h000300, 1, 8'hC3);
    settle();
    compare_ram("R9 queued command order");

    finish_run();
  end
endmodule